// File: doc/BRIEF.md
# Calibrate-and-Hold Clock Trim Controller

This block sequences the digital side of an on-chip clock source that is trimmed once against a reference clock and then runs without it. After a start request it lets the analog frequency-locking loop settle for a programmed number of reference-clock periods. It then digitises the settled oscillator control voltage with a successive-approximation search. The search drives a DAC code and reads back a comparator decision.

When the search ends, the converged code is frozen in a holding register and `done` is raised. `done` steers the analog mux so that the DAC, not the amplifier, drives the oscillator. The block also drops the enables of the converters, amplifier and comparator. The DAC, oscillator and temperature-compensation enables stay high in every phase. A restart request in the held phase sends the controller back to calibration for a fresh trim.

Top module: `trimHoldCtrl`

## Requirements
- R1: After reset `done`, `dacReset`, `dacCode` and `holdCode` are all zero and every enable is high. The controller stays in calibration, with no DAC reset pulse, until `startReq` is sampled high.
- R2: `settleCycles` = N sets the settle count, which starts at zero. It advances on each clock edge at which `refTick` is high. On the first edge at which the count already equals N, the controller leaves settling. With N = 0 this is the first edge after the start.
- R3: On leaving settling, `dacReset` is high for exactly one cycle, and `dacCode` reads 0 during that cycle. This happens before any trial.
- R4: On the edge after the reset pulse, `dacCode` becomes half scale: only the MSB is set (512 for 10 bits).
- R5: One bit is resolved per cycle, MSB first. When `cmpAbove` = 1 (DAC above input) the trial bit is cleared, and when it is 0 the bit is kept. The next lower bit is then set to 1. With `cmpAbove` = (code > V), the result equals V for every V from 0 to 1023.
- R6: The conversion takes exactly CODE_W trial cycles. On the edge that samples the LSB decision, `done` rises and `holdCode` is loaded with the final code.
- R7: While `done` is high, `enConv`, `enAmp` and `enCmp` are low and `dacCode` equals `holdCode`. Both stay unchanged whatever `cmpAbove`, `refTick` and `startReq` do.
- R8: `enDac`, `enOsc` and `enTemp` are high in every phase.
- R9: `restart` sampled while `done` is high clears `done` on that edge and raises all enables. It then restarts the settle count. `holdCode` keeps its old value until the new conversion completes.
- R10: `startReq` has no effect outside the idle calibration state, and `restart` has no effect outside retention.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startReq | input | 1 | Begin the first trim from idle |
| restart | input | 1 | Return from retention to calibration |
| refTick | input | 1 | One-cycle pulse per reference-clock period |
| settleCycles | input | SETTLE_W | Reference periods to wait for loop settling |
| cmpAbove | input | 1 | Comparator: DAC voltage above analog input |
| dacCode | output | CODE_W | Code applied to the DAC |
| dacReset | output | 1 | Discharge pulse for the charge-scaling DAC |
| holdCode | output | CODE_W | Frozen trim code |
| done | output | 1 | Retention phase; selects DAC output at the mux |
| enConv | output | 1 | Enable for the frequency-to-voltage converters |
| enAmp | output | 1 | Enable for the loop amplifier |
| enCmp | output | 1 | Enable for the ADC comparator |
| enDac | output | 1 | Enable for the DAC |
| enOsc | output | 1 | Enable for the oscillator |
| enTemp | output | 1 | Enable for temperature compensation |

## Verification
Assertions check the following on every cycle:
- the reset pulse lasts one cycle;
- the search starts from half scale;
- the hold register moves only on its load strobe;
- `done` rises only after the LSB decision;
- a restart drops `done` at once;
- the held code stays steady through retention.

Only the bench scenarios can show the absolute timing:
- the settle latency under several settle counts and reference-tick rates;
- the exact cycle of `done`;
- the converged code for every 10-bit input;
- that stray start and restart requests leave a running conversion unchanged.

// File: rtl/trimPkg.sv
package trimPkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETTLE,
    ST_DACRST,
    ST_TRIAL,
    ST_HOLD
  } trimState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic cntClr;
    logic cntInc;
    logic sarClr;
    logic sarInit;
    logic sarStep;
    logic holdLoad;
  } trimStrobe_t;

endpackage

// File: rtl/trimCtrl.sv
module trimCtrl
  import trimPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        startReq,
  input  logic        restart,
  input  logic        refTick,
  input  logic        cntDone,
  input  logic        lastBit,
  output trimStrobe_t strobe,
  output logic        done,
  output logic        dacReset,
  output logic        enConv,
  output logic        enAmp,
  output logic        enCmp
);

  trimState_e state, stateNxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  always_comb begin
    stateNxt = state;
    strobe   = '0;
    case (state)
      ST_IDLE: begin
        if (startReq) begin
          stateNxt      = ST_SETTLE;
          strobe.cntClr = 1'b1;
        end
      end
      ST_SETTLE: begin
        if (cntDone) begin
          stateNxt      = ST_DACRST;
          strobe.sarClr = 1'b1;
        end else if (refTick) begin
          strobe.cntInc = 1'b1;
        end
      end
      ST_DACRST: begin
        stateNxt       = ST_TRIAL;
        strobe.sarInit = 1'b1;
      end
      ST_TRIAL: begin
        strobe.sarStep = 1'b1;
        if (lastBit) begin
          stateNxt        = ST_HOLD;
          strobe.holdLoad = 1'b1;
        end
      end
      ST_HOLD: begin
        if (restart) begin
          stateNxt      = ST_SETTLE;
          strobe.cntClr = 1'b1;
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  assign done     = (state == ST_HOLD);
  assign dacReset = (state == ST_DACRST);
  assign enConv   = !done;
  assign enAmp    = !done;
  assign enCmp    = !done;

  // R3
  dac_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    dacReset |=> !dacReset);

  // R6
  done_after_lsb_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> $past(lastBit));

  // R9
  restart_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && restart) |=> !done);

  // R2
  settle_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dacReset) |-> $past(cntDone));

endmodule

// File: rtl/trimDatapath.sv
module trimDatapath
  import trimPkg::*;
#(
  parameter int CODE_W   = 10,
  parameter int SETTLE_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  trimStrobe_t         strobe,
  input  logic [SETTLE_W-1:0] settleCycles,
  input  logic                cmpAbove,
  output logic                cntDone,
  output logic                lastBit,
  output logic [CODE_W-1:0]   trialCode,
  output logic [CODE_W-1:0]   holdCode
);

  localparam int IDX_W = $clog2(CODE_W + 1);
  localparam logic [CODE_W-1:0] HALF_CODE = CODE_W'(1) << (CODE_W - 1);
  localparam logic [IDX_W-1:0]  TOP_IDX   = IDX_W'(CODE_W - 1);

  logic [SETTLE_W-1:0] settleCnt;
  logic [IDX_W-1:0]    bitIdx;
  logic [CODE_W-1:0]   nextCode;

  // settle counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              settleCnt <= '0;
    else if (strobe.cntClr) settleCnt <= '0;
    else if (strobe.cntInc) settleCnt <= settleCnt + 1'b1;
  end

  assign cntDone = (settleCnt >= settleCycles);

  // trial update: clear current bit on "above", arm next lower bit
  for (genvar i = 0; i < CODE_W; i++) begin : g_bit
    always_comb begin
      if (IDX_W'(i) == bitIdx)
        nextCode[i] = trialCode[i] & ~cmpAbove;
      else if (IDX_W'(i + 1) == bitIdx)
        nextCode[i] = 1'b1;
      else
        nextCode[i] = trialCode[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      trialCode <= '0;
      bitIdx    <= '0;
    end else if (strobe.sarClr) begin
      trialCode <= '0;
      bitIdx    <= '0;
    end else if (strobe.sarInit) begin
      trialCode <= HALF_CODE;
      bitIdx    <= TOP_IDX;
    end else if (strobe.sarStep) begin
      trialCode <= nextCode;
      if (bitIdx != '0) bitIdx <= bitIdx - 1'b1;
    end
  end

  assign lastBit = (bitIdx == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                holdCode <= '0;
    else if (strobe.holdLoad) holdCode <= nextCode;
  end

  // R4
  init_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.sarInit |=> (trialCode == HALF_CODE));

  // R9
  hold_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.holdLoad |=> $stable(holdCode));

  // R2
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.cntInc |-> (settleCnt < settleCycles));

endmodule

// File: rtl/trimHoldCtrl.sv
module trimHoldCtrl
  import trimPkg::*;
#(
  parameter int CODE_W   = 10,
  parameter int SETTLE_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                startReq,
  input  logic                restart,
  input  logic                refTick,
  input  logic [SETTLE_W-1:0] settleCycles,
  input  logic                cmpAbove,
  output logic [CODE_W-1:0]   dacCode,
  output logic                dacReset,
  output logic [CODE_W-1:0]   holdCode,
  output logic                done,
  output logic                enConv,
  output logic                enAmp,
  output logic                enCmp,
  output logic                enDac,
  output logic                enOsc,
  output logic                enTemp
);

  trimStrobe_t       strobe;
  logic              cntDone;
  logic              lastBit;
  logic [CODE_W-1:0] trialCode;

  trimCtrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .startReq (startReq),
    .restart  (restart),
    .refTick  (refTick),
    .cntDone  (cntDone),
    .lastBit  (lastBit),
    .strobe   (strobe),
    .done     (done),
    .dacReset (dacReset),
    .enConv   (enConv),
    .enAmp    (enAmp),
    .enCmp    (enCmp)
  );

  trimDatapath #(
    .CODE_W   (CODE_W),
    .SETTLE_W (SETTLE_W)
  ) uPath (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .settleCycles (settleCycles),
    .cmpAbove     (cmpAbove),
    .cntDone      (cntDone),
    .lastBit      (lastBit),
    .trialCode    (trialCode),
    .holdCode     (holdCode)
  );

  assign dacCode = done ? holdCode : trialCode;
  assign enDac   = 1'b1;
  assign enOsc   = 1'b1;
  assign enTemp  = 1'b1;

  // R7
  hold_steady_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && $past(done)) |-> $stable(dacCode));

endmodule

// File: tb/tb_trimHoldCtrl.sv
module tb_trimHoldCtrl;

  localparam int CODE_W   = 10;
  localparam int SETTLE_W = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startReq = 1'b0;
  logic restart = 1'b0;
  logic refTick = 1'b0;
  logic [SETTLE_W-1:0] settleCycles = '0;
  logic cmpAbove;
  logic [CODE_W-1:0] dacCode, holdCode;
  logic dacReset, done, enConv, enAmp, enCmp, enDac, enOsc, enTemp;

  int target = 0;
  int checks = 0;
  int errors = 0;
  int prevHold = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  always_comb cmpAbove = (int'(dacCode) > target);

  trimHoldCtrl #(.CODE_W(CODE_W), .SETTLE_W(SETTLE_W)) dut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .restart(restart),
    .refTick(refTick), .settleCycles(settleCycles), .cmpAbove(cmpAbove),
    .dacCode(dacCode), .dacReset(dacReset), .holdCode(holdCode), .done(done),
    .enConv(enConv), .enAmp(enAmp), .enCmp(enCmp),
    .enDac(enDac), .enOsc(enOsc), .enTemp(enTemp)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // one full trim; expected timing: dacReset after edge N*P+1, done 11 edges later
  task automatic runConv(input int n, input int p, input int v,
                         input bit fromHold, input bit noise);
    int lat;
    lat = n * p + 1;
    target = v;
    settleCycles = SETTLE_W'(n);
    @(negedge clk);
    if (fromHold) restart = 1'b1; else startReq = 1'b1;
    @(posedge clk); #1;
    if (fromHold) begin
      // R9 done drops, enables back, hold keeps old code
      chk(done == 1'b0, "R9 done cleared", int'(done), 0);
      chk({enConv, enAmp, enCmp} == 3'b111, "R9 enables restored",
          int'({enConv, enAmp, enCmp}), 7);
      chk(int'(holdCode) == prevHold, "R9 hold kept", int'(holdCode), prevHold);
    end
    @(negedge clk);
    startReq = 1'b0;
    restart = 1'b0;
    for (int k = 1; k <= lat + CODE_W + 1; k++) begin
      refTick = (k % p == 0);
      // R10 stray requests during trials
      startReq = noise && (k > lat + 1) && (k < lat + CODE_W + 1);
      restart  = startReq;
      @(posedge clk); #1;
      // R8
      if ({enDac, enOsc, enTemp} != 3'b111)
        chk(1'b0, "R8 always-on enables", int'({enDac, enOsc, enTemp}), 7);
      if (k < lat) begin
        if (dacReset) chk(1'b0, "R2 early dacReset", k, lat);
      end else if (k == lat) begin
        chk(dacReset == 1'b1, "R2 settle latency", int'(dacReset), 1);
        chk(dacCode == '0, "R3 code zero in reset", int'(dacCode), 0);
      end else if (k == lat + 1) begin
        chk(dacReset == 1'b0, "R3 single pulse", int'(dacReset), 0);
        chk(int'(dacCode) == 512, "R4 half scale start", int'(dacCode), 512);
      end else if (k == lat + CODE_W) begin
        chk(done == 1'b0, "R6 done not early", int'(done), 0);
        if (fromHold)
          chk(int'(holdCode) == prevHold, "R9 hold until finish", int'(holdCode), prevHold);
      end else if (k == lat + CODE_W + 1) begin
        chk(done == 1'b1, "R6 done timing", int'(done), 1);
        chk(int'(holdCode) == v, "R5 converged code", int'(holdCode), v);
        chk(int'(dacCode) == v, "R7 dac shows held code", int'(dacCode), v);
        chk({enConv, enAmp, enCmp} == 3'b000, "R7 blocks disabled",
            int'({enConv, enAmp, enCmp}), 0);
      end
      @(negedge clk);
    end
    startReq = 1'b0;
    restart = 1'b0;
    refTick = 1'b0;
    prevHold = v;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(done == 1'b0 && dacReset == 1'b0, "R1 reset outputs", int'({done, dacReset}), 0);
    chk(dacCode == '0 && holdCode == '0, "R1 reset codes", int'(holdCode), 0);
    chk({enConv, enAmp, enCmp, enDac, enOsc, enTemp} == 6'h3f, "R1 enables",
        int'({enConv, enAmp, enCmp, enDac, enOsc, enTemp}), 63);
    // R1 idle waits for start; R10 restart ignored in idle
    refTick = 1'b1;
    restart = 1'b1;
    for (int k = 0; k < 6; k++) begin
      @(posedge clk); #1;
      if (dacReset || done) chk(1'b0, "R1 waits for start", int'({dacReset, done}), 0);
      @(negedge clk);
    end
    refTick = 1'b0;
    restart = 1'b0;
    chk(dacReset == 1'b0, "R1 idle hold", int'(dacReset), 0);

    // R2 settle sweep over counts and tick rates
    runConv(0, 1, 300, 1'b0, 1'b0);
    for (int n = 0; n < 5; n++)
      for (int p = 1; p <= 3; p++)
        runConv(n, p, (n * 97 + p * 211 + 5) % 1024, 1'b1, (n + p) % 2 == 1);

    // R7 retention ignores comparator, ticks and start
    for (int k = 0; k < 6; k++) begin
      target = (k * 331) % 1024;
      refTick = k[0];
      startReq = 1'b1;
      @(posedge clk); #1;
      chk(done == 1'b1 && int'(dacCode) == prevHold, "R7 retention steady",
          int'(dacCode), prevHold);
      @(negedge clk);
    end
    startReq = 1'b0;
    refTick = 1'b0;

    // R5 exhaustive code sweep
    for (int v = 0; v < 1024; v++)
      runConv(0, 1, v, 1'b1, v % 7 == 0);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule